// File: doc/BRIEF.md
# Serial Receive Ring Buffer

This block holds bytes that a serial receiver hands over, one byte per receive event, until a CPU-side reader collects them. The store is a 256-entry circular memory. Two free-running 8-bit indices address it: one for writing and one for reading. Both indices only ever increment and wrap from 255 back to 0, so no bounds logic is needed.

The writer is never held back, because the system has no hardware flow control. When a byte arrives and all 256 entries are unread, the oldest unread byte is discarded so the new one can be kept. A sticky flag records that this happened, and the CPU clears it with a strobe.

The reader sees how many bytes are waiting and pops them one at a time. It also gets a level-sensitive interrupt that stays high while anything is stored.

Top module: `uart_rx_ring`

## Requirements
- R1: While `rst` is high at a clock edge, both indices return to 0, and `count`, `full`, `overrun`, `irq` and `rd_data` all become 0.
- R2: Each cycle with `rx_valid` high stores `rx_data` at the write index, which advances by one and wraps from 255 to 0. The new occupancy is visible right after that edge.
- R3: A cycle with `rd_pop` high and the buffer non-empty presents the oldest stored byte on `rd_data` right after that edge. Bytes come out in arrival order, and `rd_data` holds its value until the next accepted pop.
- R4: `count` equals the write index minus the read index, modulo 256. `full` is 1 exactly when 256 bytes are stored, in which case `count` reads 0.
- R5: A write with no pop into a full buffer advances the read index along with the write index. Exactly the oldest byte is lost, the buffer stays full, and the next pop returns the byte that was second oldest.
- R6: `overrun` becomes 1 after a write with no pop into a full buffer, and stays 1 until a cycle with `ovr_clr` high. If set and clear happen in the same cycle, the set wins.
- R7: A pop while the buffer is empty is ignored: `rd_data` keeps its previous value and `count`, `full` stay unchanged.
- R8: A write and an accepted pop in the same cycle are both performed and occupancy is unchanged. On a full buffer the pop returns the oldest byte, and the write sets no `overrun`.
- R9: `irq` is high exactly when the buffer holds at least one byte (`count` non-zero or `full`). It changes on the same edge as `count`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | One-cycle receive event strobe |
| rx_data | input | 8 | Received byte |
| rd_pop | input | 1 | Reader pop strobe |
| ovr_clr | input | 1 | Clears the sticky overrun flag |
| rd_data | output | 8 | Most recently popped byte |
| count | output | 8 | Stored bytes modulo 256 |
| full | output | 1 | All 256 entries hold unread data |
| overrun | output | 1 | Sticky flag: a byte was discarded |
| irq | output | 1 | Data-available level interrupt |

## Verification
On every cycle, the assertions check how the flags relate to each other and how they move. They cover the interrupt level against `count` and `full`, the reading of `count` as 0 while `full`, increments on plain writes, unchanged occupancy on combined write and pop, and the overrun set rule and its stickiness. They also check that `rd_data` holds across a pop on an empty buffer. What the assertions cannot see is which byte comes out. FIFO order, index wraparound after more than 256 writes, and the exact byte lost on overrun are shown only by the bench's reference queue, both in its directed fill-and-overflow scenarios and in its random traffic.

// File: rtl/uart_rx_ring_pkg.sv
package uart_rx_ring_pkg;

  // Accepted operation in one cycle: {write, accepted pop}
  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_POP  = 2'b01,
    OP_PUSH = 2'b10,
    OP_BOTH = 2'b11
  } ring_op_e;

endpackage

// File: rtl/uart_rx_ring_store.sv
// Simple dual-port storage, read-first on an address collision, shaped for
// block RAM inference with a registered read port.
module uart_rx_ring_store #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/uart_rx_ring_ctrl.sv
// Index bookkeeping: free-running write/read indices, full flag, overwrite.
module uart_rx_ring_ctrl
  import uart_rx_ring_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic              rd_pop,
  output logic [ADDR_W-1:0] wr_idx,
  output logic [ADDR_W-1:0] rd_idx,
  output logic              rd_ok,
  output logic              drop,
  output logic              level_n,
  output logic [ADDR_W-1:0] count,
  output logic              full
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  logic [ADDR_W-1:0] wr_q, rd_q, wr_n, rd_n;
  logic              full_q, full_n, empty;
  ring_op_e          op;

  assign empty = !full_q && (wr_q == rd_q);
  assign rd_ok = rd_pop && !empty;
  assign op    = ring_op_e'({rx_valid, rd_ok});

  always_comb begin
    wr_n   = wr_q;
    rd_n   = rd_q;
    full_n = full_q;
    drop   = 1'b0;
    unique case (op)
      OP_PUSH: begin
        wr_n = wr_q + ONE;
        if (full_q) begin
          rd_n = rd_q + ONE;      // oldest byte is sacrificed
          drop = 1'b1;
        end else begin
          full_n = ((wr_q + ONE) == rd_q);
        end
      end
      OP_POP: begin
        rd_n   = rd_q + ONE;
        full_n = 1'b0;
      end
      OP_BOTH: begin
        wr_n = wr_q + ONE;
        rd_n = rd_q + ONE;
      end
      default: ;
    endcase
  end

  assign level_n = full_n || (wr_n != rd_n);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q   <= '0;
      rd_q   <= '0;
      full_q <= 1'b0;
    end else begin
      wr_q   <= wr_n;
      rd_q   <= rd_n;
      full_q <= full_n;
    end
  end

  assign wr_idx = wr_q;
  assign rd_idx = rd_q;
  assign count  = wr_q - rd_q;
  assign full   = full_q;
endmodule

// File: rtl/uart_rx_ring_flags.sv
// Registered interrupt level and sticky overrun flag.
module uart_rx_ring_flags (
  input  logic clk,
  input  logic rst,
  input  logic drop,
  input  logic ovr_clr,
  input  logic level_n,
  output logic overrun,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      overrun <= 1'b0;
      irq     <= 1'b0;
    end else begin
      irq <= level_n;
      if (drop)         overrun <= 1'b1;   // set beats clear
      else if (ovr_clr) overrun <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_rx_ring.sv
module uart_rx_ring #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rd_pop,
  input  logic              ovr_clr,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] count,
  output logic              full,
  output logic              overrun,
  output logic              irq
);
  logic [ADDR_W-1:0] wr_idx, rd_idx;
  logic              rd_ok, drop, level_n;

  uart_rx_ring_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .rx_valid(rx_valid),
    .rd_pop  (rd_pop),
    .wr_idx  (wr_idx),
    .rd_idx  (rd_idx),
    .rd_ok   (rd_ok),
    .drop    (drop),
    .level_n (level_n),
    .count   (count),
    .full    (full)
  );

  uart_rx_ring_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
    .clk  (clk),
    .rst  (rst),
    .we   (rx_valid),
    .waddr(wr_idx),
    .wdata(rx_data),
    .re   (rd_ok),
    .raddr(rd_idx),
    .rdata(rd_data)
  );

  uart_rx_ring_flags u_flags (
    .clk    (clk),
    .rst    (rst),
    .drop   (drop),
    .ovr_clr(ovr_clr),
    .level_n(level_n),
    .overrun(overrun),
    .irq    (irq)
  );
endmodule

// File: rtl/uart_rx_ring_chk.sv
module uart_rx_ring_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              rx_valid,
  input logic              rd_pop,
  input logic              ovr_clr,
  input logic [DATA_W-1:0] rd_data,
  input logic [ADDR_W-1:0] count,
  input logic              full,
  input logic              overrun,
  input logic              irq
);
  AST_RESET_CLEAN: assert property (@(posedge clk)
    $past(rst) |-> (count == '0 && !full && !overrun && !irq && rd_data == '0)); // R1

  AST_WRITE_STEP: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !rd_pop && !full) |=> (count == ADDR_W'($past(count) + 1'b1))); // R2

  AST_FULL_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    full |-> (count == '0)); // R4

  AST_OVERWRITE_KEEPS_FULL: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !rd_pop && full) |=> (full && overrun)); // R5

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (overrun && !ovr_clr) |=> overrun); // R6

  AST_OVR_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (ovr_clr && !(rx_valid && full && !rd_pop)) |=> !overrun); // R6

  AST_EMPTY_POP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (rd_pop && !rx_valid && count == '0 && !full) |=> ($stable(rd_data) && count == '0 && !full)); // R7

  AST_BOTH_SAME_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rd_pop && (count != '0 || full)) |=> ($stable(count) && $stable(full))); // R8

  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (rst)
    irq == (count != '0 || full)); // R9
endmodule

bind uart_rx_ring uart_rx_ring_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .rx_valid(rx_valid),
  .rd_pop  (rd_pop),
  .ovr_clr (ovr_clr),
  .rd_data (rd_data),
  .count   (count),
  .full    (full),
  .overrun (overrun),
  .irq     (irq)
);

// File: tb/uart_rx_ring_tb.sv
module uart_rx_ring_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = '0;
  logic       rd_pop = 1'b0;
  logic       ovr_clr = 1'b0;
  logic [7:0] rd_data, count;
  logic       full, overrun, irq;

  int n_checks = 0;
  int n_fails  = 0;

  logic [7:0] q[$];
  logic [7:0] last_m = '0;
  bit         ovr_m  = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  uart_rx_ring u_dut (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
    .rd_pop(rd_pop), .ovr_clr(ovr_clr), .rd_data(rd_data), .count(count),
    .full(full), .overrun(overrun), .irq(irq)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_count();
    return q.size() % 256;
  endfunction

  // One clock of stimulus, then model update and comparison of every output.
  task automatic step(input bit w, input logic [7:0] d, input bit p, input bit c);
    bit dropped;
    @(negedge clk);
    rx_valid = w; rx_data = d; rd_pop = p; ovr_clr = c;
    @(posedge clk); #1;
    dropped = 1'b0;
    if (p && q.size() != 0) last_m = q.pop_front();
    if (w) begin
      if (q.size() == 256) begin void'(q.pop_front()); dropped = 1'b1; end
      q.push_back(d);
    end
    if (dropped) ovr_m = 1'b1;
    else if (c)  ovr_m = 1'b0;
    check(count == exp_count(),   "R4 count",   count,   exp_count());
    check(full == (q.size()==256), "R4 full",   full,    q.size()==256);
    check(irq == (q.size()!=0),    "R9 irq",    irq,     q.size()!=0);
    check(overrun == ovr_m,        "R6 overrun", overrun, ovr_m);
    check(rd_data == last_m,       "R3 rd_data", rd_data, last_m);
  endtask

  initial begin
    #(20 * 200000);
    n_fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));

    // R1: reset with a write strobe held high
    rst = 1'b1; rx_valid = 1'b1; rx_data = 8'hAA;
    repeat (3) @(posedge clk);
    #1;
    check(count == 0 && !full && !irq && !overrun && rd_data == 0, "R1 reset state",
          {count, full, irq, overrun}, 0);
    @(negedge clk); rst = 1'b0; rx_valid = 1'b0;

    // R7: pop on empty from reset
    step(0, 8'h00, 1, 0);
    check(rd_data == 8'h00 && count == 0, "R7 empty pop after reset", rd_data, 0);

    // R2/R3: a short burst in and out
    for (int i = 0; i < 5; i++) step(1, 8'h10 + 8'(i), 0, 0);
    check(count == 5, "R2 count after five writes", count, 5);
    for (int i = 0; i < 5; i++) begin
      step(0, 8'h00, 1, 0);
      check(rd_data == 8'h10 + 8'(i), "R3 arrival order", rd_data, 8'h10 + 8'(i));
    end

    // R7: empty pop keeps the last byte
    step(0, 8'h00, 1, 0);
    check(rd_data == 8'h14 && count == 0 && !full, "R7 hold last byte", rd_data, 8'h14);

    // R4/R2: fill all 256 (write index wraps past 255)
    for (int i = 0; i < 256; i++) step(1, 8'(i), 0, 0);
    check(full && count == 0 && irq, "R4 full reads zero count", {full, count}, 9'h100);

    // R5/R6: three more writes into a full buffer
    for (int i = 0; i < 3; i++) step(1, 8'hE0 + 8'(i), 0, 0);
    check(overrun && full, "R5 overwrite keeps full", {overrun, full}, 3);

    // R8: write and pop together on full: oldest survivor is byte 3
    step(1, 8'hF0, 1, 0);
    check(rd_data == 8'd3 && full && overrun, "R8 both on full", rd_data, 3);

    // R6: set wins over clear, then clear alone
    step(1, 8'hF1, 0, 1);
    check(overrun == 1'b1, "R6 set beats clear", overrun, 1);
    step(0, 8'h00, 0, 1);
    check(overrun == 1'b0, "R6 clear", overrun, 0);

    // R5: next pop returns the byte after the ones discarded
    step(0, 8'h00, 1, 0);
    check(rd_data == 8'd5 && count == 255, "R5 oldest dropped exactly", rd_data, 5);

    // R8: simultaneous write and pop on a partly filled buffer
    step(1, 8'h77, 1, 0);
    check(count == 255 && rd_data == 8'd6, "R8 both keep count", count, 255);

    // Drain, then random traffic with varying bias
    while (q.size() != 0) step(0, 8'h00, 1, 0);
    for (int ph = 0; ph < 4; ph++) begin
      for (int i = 0; i < 1500; i++) begin
        int wp = (ph == 1) ? 90 : (ph == 2) ? 20 : 55;
        step(($urandom % 100) < wp, 8'($urandom), ($urandom % 100) < 50,
             ($urandom % 100) < 5);
      end
    end

    @(negedge clk); rx_valid = 0; rd_pop = 0; ovr_clr = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule